// File: doc/BRIEF.md
# Control Register Bank with Set, Clear and Toggle Aliases

This block holds a small number of 32-bit control registers behind a word-addressed bus. Software can update a register in one write without reading it first: next to each base register sit three alias words. A write to the first alias sets bits, a write to the second clears bits and a write to the third inverts bits. A per-register protect mask keeps read-only bits fixed whatever kind of write arrives.

Each register loads its own constant at reset. Selected status bits, such as a lock indication on a clock-generator control register, are forced to 1 on top of that constant. Reads return data one cycle after the read strobe. An access that is misaligned, out of range, or aimed at an alias of a register without aliases reads as zero and is ignored on write. Such an access raises a one-cycle error flag.

The reset constants, protect masks, forced bits and alias support are parameter arrays, one entry per register.

Top module: `alias_reg_bank`

## Requirements
- R1: After reset each register k holds its reset constant ORed with its forced-bit pattern; rd_data and err are 0.
- R2: Register k owns byte addresses 16k (base), 16k+4, 16k+8 and 16k+12. A base write keeps the bits set in the protect mask and replaces every other bit with wr_data.
- R3: A write to 16k+4 ORs into register k the wr_data bits that are not protected.
- R4: A write to 16k+8 clears in register k the wr_data bits that are not protected.
- R5: A write to 16k+12 inverts in register k the wr_data bits that are not protected.
- R6: A read of any of the four addresses of register k returns its current value on rd_data in the cycle after rd_en; rd_data holds while rd_en is low.
- R7: An access with addr[1:0] not 0, with an index at or above the register count, or aimed at an alias word of a register whose alias-enable bit is 0, reads as 0, changes no register, and sets err for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| err | output | 1 | One-cycle flag for a rejected access |

## Verification
The assertions assume that addr, wr_data and the strobes are known values at each rising edge after reset, and that read and write strobes are not given in the same cycle to different registers. The bench drives all inputs on the falling edge. It raises at most one strobe per cycle and returns both strobes to 0 between accesses. The assertions can therefore relate each register's next value to exactly one decoded operation.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Word offset inside a four-word register group selects the operation.
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_INVERT = 2'd3
  } reg_op_e;

endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/rb_decode.sv
module rb_decode
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0] ALIAS_EN = '1,
  localparam int SEL_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int WORD_W = ADDR_W - 2,
  localparam int IDX_W  = WORD_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEL_W-1:0]  sel,
  output reg_op_e           op
);

  localparam logic [IDX_W:0] NREG = (IDX_W+1)'(NUM_REGS);

  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              in_range;
  logic              alias_ok;

  always_comb begin
    word     = addr[ADDR_W-1:2];
    idx      = word[WORD_W-1:2];
    op       = reg_op_e'(word[1:0]);
    sel      = idx[SEL_W-1:0];
    aligned  = (addr[1:0] == 2'b00);
    in_range = ({1'b0, idx} < NREG);
    alias_ok = (op == OP_WRITE) || (in_range && ALIAS_EN[sel]);
    hit      = aligned && in_range && alias_ok;
  end

endmodule

// File: rtl/rb_reg_slice.sv
module rb_reg_slice
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_VAL   = '0,
  parameter logic [DATA_W-1:0] RO_MASK   = '0,
  parameter logic [DATA_W-1:0] FORCE_SET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_op_e           op,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] RESET_WORD = RST_VAL | FORCE_SET;

  logic [DATA_W-1:0] open_bits;
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    open_bits = wd & ~RO_MASK;
    unique case (op)
      OP_WRITE:  q_nxt = (q & RO_MASK) | open_bits;
      OP_SET:    q_nxt = q | open_bits;
      OP_CLEAR:  q_nxt = q & ~open_bits;
      OP_INVERT: q_nxt = q ^ open_bits;
      default:   q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RESET_WORD;
    else if (wr_en) q <= q_nxt;
  end

  // R2: protected bits never move on any write
  a_r2_protected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & RO_MASK) == ($past(q) & RO_MASK)));

  // R3: every unprotected bit written through the set alias reads back as 1
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=> ((q & $past(wd) & ~RO_MASK) == ($past(wd) & ~RO_MASK)));

  // R4: every unprotected bit written through the clear alias reads back as 0
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLEAR) |=> ((q & $past(wd) & ~RO_MASK) == '0));

  // R5: the bits that changed are exactly the unprotected written ones
  a_r5_invert_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_INVERT) |=> (((q ^ $past(q)) & ~RO_MASK) == ($past(wd) & ~RO_MASK)));

  // R7: without a write strobe the register holds
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] RST_VAL =
    {32'h0000_0000, 32'hA5A5_0000, 32'h0000_00FF, 32'h0001_3001},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] RO_MASK =
    {32'hF000_000F, 32'h0000_00FF, 32'h0000_0000, 32'hFFFF_0000},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] FORCE_SET =
    {32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000},
  parameter logic [NUM_REGS-1:0] ALIAS_EN = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                             srst_n;
  logic                             hit;
  logic [SEL_W-1:0]                 sel;
  reg_op_e                          op;
  logic [NUM_REGS-1:0][DATA_W-1:0]  q_all;
  logic [NUM_REGS-1:0]              slice_we;
  logic [DATA_W-1:0]                rd_mux;
  logic [DATA_W-1:0]                rd_nxt;
  logic                             err_nxt;

  rb_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rb_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .ALIAS_EN (ALIAS_EN)
  ) u_dec (
    .addr (addr),
    .hit  (hit),
    .sel  (sel),
    .op   (op)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    assign slice_we[k] = wr_en && hit && (sel == SEL_W'(k));

    rb_reg_slice #(
      .DATA_W    (DATA_W),
      .RST_VAL   (RST_VAL[k]),
      .RO_MASK   (RO_MASK[k]),
      .FORCE_SET (FORCE_SET[k])
    ) u_slice (
      .clk   (clk),
      .rst_n (srst_n),
      .wr_en (slice_we[k]),
      .op    (op),
      .wd    (wr_data),
      .q     (q_all[k])
    );
  end

  always_comb begin
    rd_mux  = hit ? q_all[sel] : '0;
    rd_nxt  = rd_en ? rd_mux : rd_data;
    err_nxt = (wr_en || rd_en) && !hit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_data <= '0;
      err     <= 1'b0;
    end else begin
      rd_data <= rd_nxt;
      err     <= err_nxt;
    end
  end

  // R7: a rejected access flags err in the following cycle
  a_r7_err_flag: assert property (@(posedge clk) disable iff (!srst_n)
    ((wr_en || rd_en) && !hit) |=> err);

  // R7: a rejected read returns zero
  a_r7_bad_read_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && !hit) |=> (rd_data == '0));

  // R7: an accepted access or idle cycle leaves err low
  a_r7_err_single: assert property (@(posedge clk) disable iff (!srst_n)
    (!(wr_en || rd_en) || hit) |=> !err);

  // R6: rd_data holds while no read is requested
  a_r6_read_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_en |=> $stable(rd_data));

  // R2: at most one register is written per cycle
  a_r2_one_writer: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(slice_we));

endmodule

// File: tb/alias_reg_bank_tb_top.sv
module alias_reg_bank_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        err;

  int checks;
  int failures;

  alias_reg_bank dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .err     (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // One write followed by one read; req names the requirement checked.
  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic        we_err;
    logic [7:0]  ra;
    logic [31:0] rv;
    logic        re_err;
    logic [3:0]  req;
  } vec_t;

  // Reset image: r0=8001_3001 r1=0000_00FF r2=A5A5_0000 r3=8000_0000
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 32'hFFFF_FFFF, 1'b0, 8'h00, 32'h8001_FFFF, 1'b0, 4'd2}, // R2 base, upper protected
    '{8'h08, 32'hFFFF_00F0, 1'b0, 8'h04, 32'h8001_FF0F, 1'b0, 4'd4}, // R4 clear
    '{8'h0C, 32'h0000_0FFF, 1'b0, 8'h0C, 32'h8001_F0F0, 1'b0, 4'd5}, // R5 invert
    '{8'h04, 32'h1234_000F, 1'b0, 8'h08, 32'h8001_F0FF, 1'b0, 4'd3}, // R3 set
    '{8'h10, 32'hDEAD_BEEF, 1'b0, 8'h10, 32'hDEAD_BEEF, 1'b0, 4'd2}, // R2 no mask
    '{8'h18, 32'hFFFF_0000, 1'b0, 8'h1C, 32'h0000_BEEF, 1'b0, 4'd4}, // R4
    '{8'h1C, 32'hFFFF_FFFF, 1'b0, 8'h14, 32'hFFFF_4110, 1'b0, 4'd5}, // R5
    '{8'h24, 32'h0000_FFFF, 1'b0, 8'h20, 32'hA5A5_FF00, 1'b0, 4'd3}, // R3 low byte protected
    '{8'h20, 32'h1111_11FF, 1'b0, 8'h20, 32'h1111_1100, 1'b0, 4'd2}, // R2
    '{8'h30, 32'hFFFF_FFFF, 1'b0, 8'h30, 32'h8FFF_FFF0, 1'b0, 4'd2}, // R2 split mask
    '{8'h34, 32'h0000_0000, 1'b1, 8'h30, 32'h8FFF_FFF0, 1'b0, 4'd7}, // R7 alias on plain reg
    '{8'h40, 32'hFFFF_FFFF, 1'b1, 8'h34, 32'h0000_0000, 1'b1, 4'd7}, // R7 out of range
    '{8'h01, 32'h0000_0000, 1'b1, 8'h00, 32'h8001_F0FF, 1'b0, 4'd7}, // R7 misaligned write
    '{8'h2C, 32'h0000_0101, 1'b0, 8'h28, 32'h1111_1000, 1'b0, 4'd5}, // R5 partly protected
    '{8'hFC, 32'hFFFF_FFFF, 1'b1, 8'h02, 32'h0000_0000, 1'b1, 4'd7}, // R7 misaligned read
    '{8'h08, 32'hFFFF_FFFF, 1'b0, 8'h0C, 32'h8001_0000, 1'b0, 4'd6}  // R6 lock bit survives clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr    = a;
    wr_data = d;
    wr_en   = we;
    rd_en   = !we;
    @(negedge clk);
    wr_en   = 1'b0;
    rd_en   = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0;
    addr = '0; wr_data = '0; wr_en = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
    do_reset();

    // R1: reset state of outputs and registers
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 err", {31'b0, err}, 32'h0);
    access(1'b0, 8'h00, '0); check("R1 reg0", rd_data, 32'h8001_3001);
    access(1'b0, 8'h10, '0); check("R1 reg1", rd_data, 32'h0000_00FF);
    access(1'b0, 8'h20, '0); check("R1 reg2", rd_data, 32'hA5A5_0000);
    access(1'b0, 8'h30, '0); check("R1 reg3", rd_data, 32'h8000_0000);

    for (int i = 0; i < NV; i++) begin
      access(1'b1, VEC[i].wa, VEC[i].wd);
      check($sformatf("R%0d vec%0d write err", VEC[i].req, i), {31'b0, err}, {31'b0, VEC[i].we_err});
      access(1'b0, VEC[i].ra, '0);
      check($sformatf("R%0d vec%0d read", VEC[i].req, i), rd_data, VEC[i].rv);
      check($sformatf("R%0d vec%0d read err", VEC[i].req, i), {31'b0, err}, {31'b0, VEC[i].re_err});
    end

    // R6: rd_data holds while rd_en stays low
    repeat (3) @(negedge clk);
    check("R6 hold", rd_data, 32'h8001_0000);

    // R7: err lasts a single cycle
    access(1'b1, 8'h41, 32'h1);
    check("R7 err set", {31'b0, err}, 32'h1);
    @(negedge clk);
    check("R7 err one cycle", {31'b0, err}, 32'h0);

    // R1: a later reset restores constants and forced lock bits
    do_reset();
    access(1'b0, 8'h04, '0); check("R1 reg0 after reset", rd_data, 32'h8001_3001);
    access(1'b0, 8'h30, '0); check("R1 reg3 after reset", rd_data, 32'h8000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule